// File: doc/BRIEF.md
# Reservation Monitor for Linked Load / Conditional Store

This block sits between one core's memory request port and a shared, word-addressed memory. It holds one reservation: a word address and a valid flag. A linked load returns the memory word to the core and sets the reservation on that address. Any write that touches the reserved word before the matching conditional store clears the reservation. The write may come from the local core as a normal store, or from another agent reported on a snoop port.

A conditional store writes memory only while the reservation is still valid and names the same word. It returns 1 on success and 0 on failure, and the core places that value in its destination register. Software loops on a 0 result. Each retry issues a fresh linked load, which arms the reservation again. A read and a write to one word can then act as a single atomic exchange without locking the bus.

The request path is combinational, with one request per cycle. Address, data and write enable pass straight to the memory, and the result is available in the same cycle. The reservation state changes on the clock edge that ends the request. The number of snoop ports is a parameter.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no reservation is held. A conditional store (req_op = 3) issued before any linked load returns rd_value = 0 and keeps mem_we low.
- R2: A linked load (req_op = 2) drives rd_valid high and rd_value equal to mem_rdata, keeps mem_we low, and reserves req_addr from the next cycle on.
- R3: A conditional store to the reserved address, while the reservation is valid and no snoop write hits that address in the same cycle, drives mem_we high with mem_addr = req_addr and mem_wdata = req_wdata. It returns rd_value = 1 with rd_valid high.
- R4: A conditional store that fails keeps mem_we low and returns rd_value = 0 with rd_valid high. Memory keeps its old contents.
- R5: Every conditional store, whether it succeeds or fails, clears the reservation. A second conditional store with no linked load in between fails.
- R6: A conditional store whose address differs from the reserved address fails.
- R7: A snoop write (snoop_valid bit k, address in snoop_addr bits [k*ADDR_W +: ADDR_W]) to the reserved address clears the reservation. If the snoop write arrives in the same cycle as the conditional store, that store fails.
- R8: A normal store (req_op = 1) always writes memory (mem_we high). If its address is the reserved one, it also clears the reservation.
- R9: Snoop writes and local stores to other addresses leave the reservation intact. A later conditional store to the reserved address still succeeds.
- R10: A linked load re-arms the reservation after a failure. A linked load to a new address moves the reservation, so a conditional store to the old address fails.
- R11: A normal load (req_op = 0) drives rd_valid high and rd_value = mem_rdata, keeps mem_we low, and does not change the reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core request present this cycle |
| req_op | input | 2 | 0 load, 1 store, 2 linked load, 3 conditional store |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Store data |
| snoop_valid | input | NUM_SNOOP | One bit per snoop port: another agent writes this cycle |
| snoop_addr | input | NUM_SNOOP*ADDR_W | Packed snoop write addresses, port k at [k*ADDR_W +: ADDR_W] |
| mem_rdata | input | DATA_W | Read data from memory at mem_addr |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| rd_valid | output | 1 | rd_value is meant for the destination register |
| rd_value | output | DATA_W | Load data, or 1/0 conditional store result |

## Verification
The hardest case to reach is a snoop write that lands in exactly the same cycle as the conditional store it must defeat. It has to be told apart from snoop writes one cycle earlier and from snoop writes to neighbouring words. The directed tasks issue each request on its own clock and drive the snoop port in the same or an adjacent cycle. The address is either the reserved word or the one next to it, and each store must succeed or fail accordingly. Memory contents are read back afterwards with normal loads. This confirms that a failed store left the word unchanged.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
   typedef enum logic [1:0] {
      OP_LOAD  = 2'd0,
      OP_STORE = 2'd1,
      OP_LINK  = 2'd2,
      OP_COND  = 2'd3
   } req_op_e;
endpackage

// File: rtl/llsc_addr_match.sv
// Compares every snoop write address against the held reservation and
// against the address of the current request.
module llsc_addr_match #(
   parameter int ADDR_W    = 8,
   parameter int NUM_SNOOP = 2
) (
   input  logic [NUM_SNOOP-1:0]        snoop_valid,
   input  logic [NUM_SNOOP*ADDR_W-1:0] snoop_addr,
   input  logic [ADDR_W-1:0]           resv_addr,
   input  logic [ADDR_W-1:0]           req_addr,
   output logic                        hit_resv,
   output logic                        hit_req
);
   logic [NUM_SNOOP-1:0] hit_resv_v;
   logic [NUM_SNOOP-1:0] hit_req_v;

   for (genvar k = 0; k < NUM_SNOOP; k++) begin : g_port
      logic [ADDR_W-1:0] a;
      assign a             = snoop_addr[k*ADDR_W +: ADDR_W];
      assign hit_resv_v[k] = snoop_valid[k] && (a == resv_addr);
      assign hit_req_v[k]  = snoop_valid[k] && (a == req_addr);
   end

   assign hit_resv = |hit_resv_v;
   assign hit_req  = |hit_req_v;
endmodule

// File: rtl/llsc_resv_reg.sv
// Single reservation register. Arming has priority over clearing.
module llsc_resv_reg #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic [ADDR_W-1:0] arm_addr,
   input  logic              kill,
   output logic              resv_valid,
   output logic [ADDR_W-1:0] resv_addr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resv_valid <= 1'b0;
         resv_addr  <= '0;
      end else if (arm) begin
         resv_valid <= 1'b1;
         resv_addr  <= arm_addr;
      end else if (kill) begin
         resv_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int NUM_SNOOP = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  logic [1:0]                  req_op,
   input  logic [ADDR_W-1:0]           req_addr,
   input  logic [DATA_W-1:0]           req_wdata,
   input  logic [NUM_SNOOP-1:0]        snoop_valid,
   input  logic [NUM_SNOOP*ADDR_W-1:0] snoop_addr,
   input  logic [DATA_W-1:0]           mem_rdata,
   output logic                        mem_we,
   output logic [ADDR_W-1:0]           mem_addr,
   output logic [DATA_W-1:0]           mem_wdata,
   output logic                        rd_valid,
   output logic [DATA_W-1:0]           rd_value
);
   import llsc_pkg::*;

   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
      initial $fatal(1, "llsc_monitor: ADDR_W must be 1..32");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      initial $fatal(1, "llsc_monitor: DATA_W must be at least 1");
   end
   if (NUM_SNOOP < 1) begin : g_bad_snoop
      initial $fatal(1, "llsc_monitor: NUM_SNOOP must be at least 1");
   end

   req_op_e           op;
   logic              is_load, is_store, is_link, is_cond;
   logic              resv_valid;
   logic [ADDR_W-1:0] resv_addr;
   logic              snoop_hit_resv, snoop_hit_req;
   logic              addr_is_resv;
   logic              cond_pass;
   logic              arm, kill;

   assign op       = req_op_e'(req_op);
   assign is_load  = req_valid && (op == OP_LOAD);
   assign is_store = req_valid && (op == OP_STORE);
   assign is_link  = req_valid && (op == OP_LINK);
   assign is_cond  = req_valid && (op == OP_COND);

   llsc_addr_match #(.ADDR_W(ADDR_W), .NUM_SNOOP(NUM_SNOOP)) u_match (
      .snoop_valid (snoop_valid),
      .snoop_addr  (snoop_addr),
      .resv_addr   (resv_addr),
      .req_addr    (req_addr),
      .hit_resv    (snoop_hit_resv),
      .hit_req     (snoop_hit_req)
   );

   assign addr_is_resv = resv_valid && (resv_addr == req_addr);
   // A snoop write to the reserved word in the same cycle beats the store.
   assign cond_pass    = is_cond && addr_is_resv && !snoop_hit_resv;

   // A linked load whose own word is overwritten by a snoop in the same
   // cycle gets no reservation.
   assign arm  = is_link && !snoop_hit_req;
   assign kill = is_cond || is_link || snoop_hit_resv || (is_store && addr_is_resv);

   llsc_resv_reg #(.ADDR_W(ADDR_W)) u_resv (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm        (arm),
      .arm_addr   (req_addr),
      .kill       (kill),
      .resv_valid (resv_valid),
      .resv_addr  (resv_addr)
   );

   assign mem_we    = is_store || cond_pass;
   assign mem_addr  = req_addr;
   assign mem_wdata = req_wdata;
   assign rd_valid  = is_load || is_link || is_cond;

   always_comb begin
      rd_value = '0;
      if (is_cond)
         rd_value[0] = cond_pass;
      else if (is_load || is_link)
         rd_value = mem_rdata;
   end
endmodule

// File: rtl/llsc_monitor_sva.sv
module llsc_monitor_sva #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int NUM_SNOOP = 2
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        req_valid,
   input logic [1:0]                  req_op,
   input logic [ADDR_W-1:0]           req_addr,
   input logic [DATA_W-1:0]           req_wdata,
   input logic [NUM_SNOOP-1:0]        snoop_valid,
   input logic [NUM_SNOOP*ADDR_W-1:0] snoop_addr,
   input logic [DATA_W-1:0]           mem_rdata,
   input logic                        mem_we,
   input logic [ADDR_W-1:0]           mem_addr,
   input logic [DATA_W-1:0]           mem_wdata,
   input logic                        rd_valid,
   input logic [DATA_W-1:0]           rd_value
);
   logic cond_now;
   assign cond_now = req_valid && (req_op == 2'd3);

   // R2: linked load returns memory data and does not write
   assert_link_reads_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 2'd2) |-> (rd_valid && rd_value == mem_rdata && !mem_we));

   // R3: a successful conditional store writes its own address and data
   assert_cond_pass_writes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_now && rd_value[0]) |-> (mem_we && mem_addr == req_addr && mem_wdata == req_wdata));

   // R4: a failed conditional store never writes
   assert_cond_fail_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_now && !rd_value[0]) |-> !mem_we);

   // R5: back-to-back conditional stores: the second one fails
   assert_cond_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cond_now |=> !(cond_now && rd_value[0]));

   // R7: a snoop write one cycle earlier to the same word defeats the store
   assert_snoop_kills_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_now && $past(snoop_valid[0]) && rst_n &&
       req_addr == $past(snoop_addr[ADDR_W-1:0])) |-> !rd_value[0]);

   // R11: only stores and conditional stores may write memory
   assert_we_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (req_valid && (req_op == 2'd1 || req_op == 2'd3)));
endmodule

bind llsc_monitor llsc_monitor_sva #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SNOOP(NUM_SNOOP)
) u_sva (.*);

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb;
   localparam int AW = 8;
   localparam int DW = 32;
   localparam int NS = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [NS-1:0] snoop_valid = '0;
   logic [NS*AW-1:0] snoop_addr = '0;
   logic [DW-1:0] mem_rdata;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          rd_valid;
   logic [DW-1:0] rd_value;

   int checks = 0;
   int errors = 0;
   logic          g_we, g_rdv;
   logic [DW-1:0] g_rd;

   logic [DW-1:0] mem [0:(1<<AW)-1];

   always #10 clk = ~clk;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < (1<<AW); i++) mem[i] <= 32'h1000 + i * 3;
      end else if (mem_we) begin
         mem[mem_addr] <= mem_wdata;
      end
   end
   assign mem_rdata = mem[mem_addr];

   llsc_monitor #(.ADDR_W(AW), .DATA_W(DW), .NUM_SNOOP(NS)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .snoop_valid(snoop_valid),
      .snoop_addr(snoop_addr), .mem_rdata(mem_rdata), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rd_valid(rd_valid),
      .rd_value(rd_value)
   );

   function automatic logic [DW-1:0] init_val(input int a);
      return 32'h1000 + a * 3;
   endfunction

   task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // One request: inputs at negedge, outputs captured before the next posedge.
   task automatic req(input logic v, input logic [1:0] op, input int a, input logic [DW-1:0] d,
                      input logic [NS-1:0] sv, input int sa0, input int sa1);
      @(negedge clk);
      req_valid   = v;
      req_op      = op;
      req_addr    = AW'(a);
      req_wdata   = d;
      snoop_valid = sv;
      snoop_addr  = {AW'(sa1), AW'(sa0)};
      #3;
      g_we  = mem_we;
      g_rdv = rd_valid;
      g_rd  = rd_value;
      @(posedge clk);
      #1;
      req_valid   = 1'b0;
      snoop_valid = '0;
   endtask

   task automatic ld(input int a);             req(1, 2'd0, a, 0, 0, 0, 0); endtask
   task automatic st(input int a, input int d); req(1, 2'd1, a, DW'(d), 0, 0, 0); endtask
   task automatic ll(input int a);             req(1, 2'd2, a, 0, 0, 0, 0); endtask
   task automatic sc(input int a, input int d); req(1, 2'd3, a, DW'(d), 0, 0, 0); endtask
   task automatic snoop(input int k, input int a);
      req(0, 2'd0, 0, 0, NS'(1 << k), (k == 0) ? a : 0, (k == 1) ? a : 0);
   endtask

   task automatic t_reset;
      check("R1 mem_we idle at reset", DW'(mem_we), 0);
      sc(5, 32'hDEAD);
      check("R1 sc before any ll result", g_rd, 0);
      check("R1 sc before any ll no write", DW'(g_we), 0);
      ld(5);
      check("R4 failed sc left memory", g_rd, init_val(5));
   endtask

   task automatic t_basic;
      ll(10);
      check("R2 ll returns word", g_rd, init_val(10));
      check("R2 ll rd_valid", DW'(g_rdv), 1);
      check("R2 ll no write", DW'(g_we), 0);
      sc(10, 32'hAA55);
      check("R3 sc success result", g_rd, 1);
      check("R3 sc success write", DW'(g_we), 1);
      ld(10);
      check("R3 sc data in memory", g_rd, 32'hAA55);
   endtask

   task automatic t_clears;
      ll(12);
      sc(12, 32'h111);
      check("R5 first sc passes", g_rd, 1);
      sc(12, 32'h222);
      check("R5 second sc fails", g_rd, 0);
      check("R4 second sc rd_valid", DW'(g_rdv), 1);
      check("R4 second sc no write", DW'(g_we), 0);
      ld(12);
      check("R4 memory keeps first sc data", g_rd, 32'h111);
   endtask

   task automatic t_mismatch;
      ll(20);
      sc(21, 32'h5);
      check("R6 sc to other address fails", g_rd, 0);
      sc(20, 32'h6);
      check("R5 failed sc also cleared", g_rd, 0);
   endtask

   task automatic t_snoop;
      ll(30);
      snoop(0, 30);
      sc(30, 32'h7);
      check("R7 snoop before sc kills it", g_rd, 0);
      ll(31);
      req(1, 2'd3, 31, 32'h8, 2'b10, 0, 31);
      check("R7 same-cycle snoop fails sc", g_rd, 0);
      check("R7 same-cycle snoop no write", DW'(g_we), 0);
   endtask

   task automatic t_store;
      ll(40);
      st(40, 32'h4040);
      check("R8 store writes", DW'(g_we), 1);
      sc(40, 32'h9);
      check("R8 store to reserved word kills sc", g_rd, 0);
      ld(40);
      check("R8 memory holds store data", g_rd, 32'h4040);
   endtask

   task automatic t_other;
      ll(50);
      snoop(1, 51);
      st(52, 32'h52);
      ld(50);
      check("R11 load returns word", g_rd, init_val(50));
      check("R11 load no write", DW'(g_we), 0);
      check("R11 load rd_valid", DW'(g_rdv), 1);
      sc(50, 32'h5050);
      check("R9 unrelated writes keep reservation", g_rd, 1);
   endtask

   task automatic t_rearm;
      ll(60);
      snoop(0, 60);
      sc(60, 32'h1);
      check("R10 sc fails before retry", g_rd, 0);
      ll(60);
      sc(60, 32'h6060);
      check("R10 retry ll re-arms", g_rd, 1);
      ll(70);
      ll(71);
      sc(70, 32'h2);
      check("R10 old address lost after new ll", g_rd, 0);
      ll(71);
      sc(71, 32'h7171);
      check("R10 new address reserved", g_rd, 1);
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_basic;
      t_clears;
      t_mismatch;
      t_snoop;
      t_store;
      t_other;
      t_rearm;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule